// File: doc/BRIEF.md
# Cascadable Four-Bit Magnitude Comparator Cell

This cell compares two unsigned four-bit words and reports the result on three flags: greater, less and equal. The comparison works on the raw bit pattern with bit 3 weighted highest. Any monotonic code therefore compares correctly, BCD digits included. The cell is purely combinational: it has no clock and no reset, and every output is defined for every input combination.

Three cascade inputs carry a verdict in from a less significant cell. When the two local words differ, the cascade inputs have no effect. When the words match, the cascade inputs decide the outputs. This lets identical cells be chained with no glue logic. The least significant cell of a chain takes the cascade value greater=0, less=0, equal=1. Each cell's three outputs then drive the matching cascade inputs of the next more significant cell.

Cascade combinations that are not one-hot also give fully defined outputs. Parallel expansion schemes rely on these outputs.

Top module: `mag_cmp_cell`

## Requirements
- R1: When the unsigned value of `a` exceeds that of `b`, the outputs are gt=1, lt=0, eq=0, for every value of the cascade inputs.
- R2: When the unsigned value of `a` is below that of `b`, the outputs are gt=0, lt=1, eq=0, for every value of the cascade inputs.
- R3: When `a` equals `b` and `cin_eq` is 1, the outputs are gt=0, lt=0, eq=1, whatever `cin_gt` and `cin_lt` carry.
- R4: When `a` equals `b`, `cin_eq` is 0 and exactly one of `cin_gt`/`cin_lt` is 1, that flag appears on the matching output, the other output is 0, and eq is 0.
- R5: When `a` equals `b`, `cin_eq` is 0 and both `cin_gt` and `cin_lt` are 1, all three outputs are 0.
- R6: When `a` equals `b` and all three cascade inputs are 0, the outputs are gt=1, lt=1, eq=0.
- R7: Two cells in a ripple chain compare 8-bit unsigned words correctly. In this chain, the low cell takes bits 3:0 and has its cascade inputs tied to (gt=0, lt=0, eq=1). The high cell takes bits 7:4 and takes its cascade inputs from the low cell's outputs.
- R8: The outputs are combinational and never unknown for known inputs. They reflect new inputs in the same cycle, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First word, bit 3 most significant |
| b | input | 4 | Second word, bit 3 most significant |
| cin_gt | input | 1 | Cascade greater flag from the less significant stage |
| cin_lt | input | 1 | Cascade less flag from the less significant stage |
| cin_eq | input | 1 | Cascade equal flag from the less significant stage |
| gt | output | 1 | a greater than b |
| lt | output | 1 | a less than b |
| eq | output | 1 | a equal to b |

## Verification
The hardest situations to reach are the abnormal cascade patterns, meaning both flags high or all three low. These only matter when the two local words are exactly equal, which is 16 of the 256 word pairs. Random stimulus would rarely land on them. The driver therefore walks all 2048 combinations of the eleven inputs, which covers every cascade pattern against every equal pair. A two-cell chain is then driven with 8-bit pairs. These pairs are chosen so that some differ only in the low nibble and others only in the high nibble, so both the cascade hand-off and the cascade-ignored path are exercised.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } mcmp_rel_t;

  // Relation of one bit pair.
  function automatic mcmp_rel_t mcmp_bit_rel(input logic abit, input logic bbit);
    mcmp_rel_t r;
    r.gt = abit & ~bbit;
    r.lt = ~abit & bbit;
    r.eq = ~(abit ^ bbit);
    return r;
  endfunction

  // Combine a more significant relation with a less significant one:
  // the upper pair wins unless it is equal.
  function automatic mcmp_rel_t mcmp_fold(input mcmp_rel_t upper, input mcmp_rel_t lower);
    return upper.eq ? lower : upper;
  endfunction

  // Output seen when the words match, as a function of the cascade flags.
  // Non-one-hot cascade values give defined results used by parallel expansion.
  function automatic mcmp_rel_t mcmp_cascade(input mcmp_rel_t cin);
    mcmp_rel_t r;
    r.gt = ~cin.eq & ~cin.lt;
    r.lt = ~cin.eq & ~cin.gt;
    r.eq = cin.eq;
    return r;
  endfunction

endpackage

// File: rtl/mcmp_bitpair_array.sv
module mcmp_bitpair_array
  import mcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]      a_i,
  input  logic [WIDTH-1:0]      b_i,
  output mcmp_rel_t [WIDTH-1:0] rel_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    assign rel_o[i] = mcmp_bit_rel(a_i[i], b_i[i]);
  end

endmodule

// File: rtl/mcmp_msb_scan.sv
module mcmp_msb_scan
  import mcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mcmp_rel_t [WIDTH-1:0] rel_i,
  output mcmp_rel_t             word_o
);

  always_comb begin
    mcmp_rel_t acc;
    acc = rel_i[0];
    for (int i = 1; i < WIDTH; i++) begin
      acc = mcmp_fold(rel_i[i], acc);
    end
    word_o = acc;
  end

  // A word-level verdict is never ambiguous.
  always_comb begin
    AST_WORD_ONEHOT: assert ($onehot({word_o.gt, word_o.lt, word_o.eq}) || $isunknown(rel_i)); // R1
  end

endmodule

// File: rtl/mcmp_cascade_resolve.sv
module mcmp_cascade_resolve
  import mcmp_pkg::*;
(
  input  mcmp_rel_t word_i,
  input  mcmp_rel_t cin_i,
  output mcmp_rel_t res_o
);

  mcmp_rel_t from_cascade;
  logic      cascade_used;

  assign from_cascade = mcmp_cascade(cin_i);
  assign cascade_used = word_i.eq;
  assign res_o        = cascade_used ? from_cascade : word_i;

  always_comb begin
    if (!$isunknown({word_i, cin_i})) begin
      AST_DIFF_DECIDES: assert (cascade_used || (res_o == word_i)); // R2
      AST_EQ_IN_WINS: assert (!(cascade_used && cin_i.eq) || (res_o == 3'b001)); // R3
      AST_BOTH_HIGH_NONE: assert (!(cascade_used && !cin_i.eq && cin_i.gt && cin_i.lt) || (res_o == 3'b000)); // R5
      AST_ALL_LOW_BOTH: assert (!(cascade_used && (cin_i == 3'b000)) || (res_o == 3'b110)); // R6
    end
  end

endmodule

// File: rtl/mag_cmp_cell.sv
module mag_cmp_cell
  import mcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin_gt,
  input  logic             cin_lt,
  input  logic             cin_eq,
  output logic             gt,
  output logic             lt,
  output logic             eq
);

  mcmp_rel_t [WIDTH-1:0] pair_rel;
  mcmp_rel_t             word_rel;
  mcmp_rel_t             cin_rel;
  mcmp_rel_t             result;

  assign cin_rel = '{gt: cin_gt, lt: cin_lt, eq: cin_eq};

  mcmp_bitpair_array #(.WIDTH(WIDTH)) pairs_i (
    .a_i   (a),
    .b_i   (b),
    .rel_o (pair_rel)
  );

  mcmp_msb_scan #(.WIDTH(WIDTH)) scan_i (
    .rel_i  (pair_rel),
    .word_o (word_rel)
  );

  mcmp_cascade_resolve resolve_i (
    .word_i (word_rel),
    .cin_i  (cin_rel),
    .res_o  (result)
  );

  assign gt = result.gt;
  assign lt = result.lt;
  assign eq = result.eq;

  always_comb begin
    if (!$isunknown({a, b, cin_gt, cin_lt, cin_eq})) begin
      AST_OUT_KNOWN: assert (!$isunknown({gt, lt, eq})); // R8
      AST_A_ABOVE: assert (!(a > b) || ({gt, lt, eq} == 3'b100)); // R1
      AST_A_BELOW: assert (!(a < b) || ({gt, lt, eq} == 3'b010)); // R2
      AST_ONE_FLAG_PASSES: assert (!((a == b) && !cin_eq && (cin_gt ^ cin_lt)) || ({gt, lt, eq} == {cin_gt, cin_lt, 1'b0})); // R4
    end
  end

endmodule

// File: tb/mag_cmp_cell_tb_top.sv
`timescale 1ns/1ps
module mag_cmp_cell_tb_top;

  localparam int W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [W-1:0] a, b;
  logic cin_gt, cin_lt, cin_eq;
  logic gt, lt, eq;

  logic [2*W-1:0] wa, wb;
  logic lo_gt, lo_lt, lo_eq, hi_gt, hi_lt, hi_eq;

  mag_cmp_cell #(.WIDTH(W)) dut_i (
    .a(a), .b(b), .cin_gt(cin_gt), .cin_lt(cin_lt), .cin_eq(cin_eq),
    .gt(gt), .lt(lt), .eq(eq)
  );

  mag_cmp_cell #(.WIDTH(W)) chain_lo_i (
    .a(wa[W-1:0]), .b(wb[W-1:0]), .cin_gt(1'b0), .cin_lt(1'b0), .cin_eq(1'b1),
    .gt(lo_gt), .lt(lo_lt), .eq(lo_eq)
  );

  mag_cmp_cell #(.WIDTH(W)) chain_hi_i (
    .a(wa[2*W-1:W]), .b(wb[2*W-1:W]), .cin_gt(lo_gt), .cin_lt(lo_lt), .cin_eq(lo_eq),
    .gt(hi_gt), .lt(hi_lt), .eq(hi_eq)
  );

  typedef struct {
    logic [2:0] exp;
    bit         chain;
    string      req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic push_item(input logic [2:0] exp, input bit chain, input string req);
    item_t it;
    it.exp = exp;
    it.chain = chain;
    it.req = req;
    q.push_back(it);
  endtask

  // Reference model written from the requirements: integer compare, then cascade rules.
  task automatic single_model(input int av, input int bv, input logic cg, input logic cl,
                              input logic ce, output logic [2:0] exp, output string req);
    if (av > bv)              begin exp = 3'b100; req = "R1"; end
    else if (av < bv)         begin exp = 3'b010; req = "R2"; end
    else if (ce)              begin exp = 3'b001; req = "R3"; end
    else if (cg && cl)        begin exp = 3'b000; req = "R5"; end
    else if (!cg && !cl)      begin exp = 3'b110; req = "R6"; end
    else                      begin exp = {cg, cl, 1'b0}; req = "R4"; end
  endtask

  // Driver
  initial begin
    logic [2:0] exp;
    string req;
    rst_n = 1'b0;
    a = '0; b = '0; cin_gt = 1'b0; cin_lt = 1'b0; cin_eq = 1'b1;
    wa = '0; wb = '0;
    repeat (3) @(negedge clk);
    #1;
    n_chk++;
    if ($isunknown({gt, lt, eq}) || {gt, lt, eq} !== 3'b001) begin
      n_fail++;
      $display("FAIL R8 reset idle: got %b expected 001", {gt, lt, eq});
    end
    rst_n = 1'b1;

    for (int v = 0; v < 2048; v++) begin
      @(negedge clk);
      {a, b, cin_gt, cin_lt, cin_eq} = v[10:0];
      single_model(int'(a), int'(b), cin_gt, cin_lt, cin_eq, exp, req);
      push_item(exp, 1'b0, req);
    end

    for (int k = 0; k < 96; k++) begin
      @(negedge clk);
      wa = 8'(k * 37 + 5);
      case (k % 4)
        0: wb = wa;
        1: wb = wa ^ 8'h01;
        2: wb = 8'(k * 91 + 3);
        default: wb = wa ^ 8'h10;
      endcase
      if (wa > wb)      exp = 3'b100;
      else if (wa < wb) exp = 3'b010;
      else              exp = 3'b001;
      push_item(exp, 1'b1, "R7");
    end

    @(posedge clk);
    #2;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // Monitor
  initial begin
    item_t it;
    logic [2:0] got;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        got = it.chain ? {hi_gt, hi_lt, hi_eq} : {gt, lt, eq};
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: a=%h b=%h wa=%h wb=%h cin=%b got %b expected %b",
                   it.req, a, b, wa, wb, {cin_gt, cin_lt, cin_eq}, got, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule